// File: doc/BRIEF.md
# Interrupt Injection Register Block

This block is a small memory-mapped peripheral that lets bus software raise or drop four interrupt-pending lines: machine external, supervisor external, machine software and supervisor software. It holds two 32-bit word registers behind a simple slave port. One register returns a fixed identification word. The other acts as a command port. Bit 31 of a command word gives the level to apply. The lower bits choose which pending lines take that level, so one write can set or clear several lines at once.

Access checking happens in the same cycle as the request. A request that is not a naturally aligned 32-bit word, or that hits no defined address, raises a fault pulse in that cycle. A command word with any bit set outside the four interrupt positions also faults and changes no state. A configuration input says whether supervisor mode exists. When it is low, the supervisor software line is held at zero, and a write that selects it is still accepted.

Top module: `irq_inject_regs`

## Requirements
- R1: A request whose size code is not 2 (size codes: 0 = byte, 1 = half, 2 = word, 3 = double), or whose address has either of its two low bits set, raises `acc_fault` in the same cycle, for both reads and writes.
- R2: A word read at BASE_ADDR returns 0x00010000 on `acc_rdata` in the same cycle, with no fault.
- R3: A word read at BASE_ADDR+4 returns zero with no fault, whatever the pending state.
- R4: A word access to any address other than BASE_ADDR and BASE_ADDR+4 raises `acc_fault`.
- R5: A word write at BASE_ADDR is accepted without fault and leaves `irq_pend` unchanged.
- R6: A word write at BASE_ADDR+4 with any bit among 30..0 set other than bits 11, 9, 3 and 1 faults, and `irq_pend` keeps its value.
- R7: An accepted write at BASE_ADDR+4 copies write-data bit 31, on the next clock edge, into each selected line. Bit 11 selects `irq_pend[3]` (machine external), bit 9 selects `irq_pend[2]` (supervisor external) and bit 3 selects `irq_pend[1]` (machine software). Unselected lines hold their value.
- R8: Write-data bit 1 selects `irq_pend[0]` (supervisor software) only while `sup_mode_en` is high. On any clock edge where `sup_mode_en` is low, `irq_pend[0]` becomes zero, and a write that selects it is still accepted.
- R9: While `rst` is high at a clock edge, all of `irq_pend` is cleared.
- R10: Reads and faulting requests never change `irq_pend`. With no request, `acc_fault` and `acc_rdata` are zero. `acc_rdata` is zero on any write or faulting access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode_en | input | 1 | High when supervisor mode is present |
| acc_valid | input | 1 | Request strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the request |
| acc_size | input | 3 | Size code, 2 = 32-bit word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the request cycle |
| acc_fault | output | 1 | Access fault, valid in the request cycle |
| irq_pend | output | 4 | Pending lines {mext, sext, msw, ssw} |

## Verification
The bench builds the block with ADDR_W = 6 and BASE_ADDR = 0x10. This makes the whole 64-entry address space small enough to sweep at every size code, for both reads and writes. Each access checks the fault, the read data and the pending lines after it. The bench then drives all 16 select combinations with both values, once with supervisor mode present and once with it absent, and sets each of the 27 reserved bits in turn. It also checks the clearing of the supervisor software line when supervisor mode is dropped, and a reset during operation.

// File: rtl/irq_inject_pkg.sv
package irq_inject_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned NUM_LINES   = 4;
    localparam int unsigned LEVEL_BIT   = 31;
    localparam logic [2:0]  SIZE_WORD   = 3'd2;
    localparam logic [WORD_W-1:0] ID_WORD = 32'h0001_0000;

    // Line index -> select bit position in the command word.
    // Index 0 is the supervisor software line (gated by mode).
    localparam int unsigned SSW_IDX = 0;

    function automatic int unsigned sel_pos(input int unsigned idx);
        case (idx)
            0:       sel_pos = 1;
            1:       sel_pos = 3;
            2:       sel_pos = 9;
            default: sel_pos = 11;
        endcase
    endfunction

    function automatic logic [LEVEL_BIT-1:0] sel_mask();
        logic [LEVEL_BIT-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < NUM_LINES; i++) m[sel_pos(i)] = 1'b1;
        return m;
    endfunction

    localparam logic [LEVEL_BIT-1:0] SEL_MASK = sel_mask();

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ID   = 2'd1,
        TGT_CMD  = 2'd2
    } target_e;

    typedef struct packed {
        logic    fault;
        logic    accept;
        logic    is_write;
        target_e tgt;
    } acc_dec_t;

    typedef struct packed {
        logic                 apply;
        logic                 level;
        logic [NUM_LINES-1:0] pick;
    } cmd_t;

    function automatic logic [NUM_LINES-1:0] gather_pick(input logic [WORD_W-1:0] w);
        logic [NUM_LINES-1:0] p;
        for (int unsigned i = 0; i < NUM_LINES; i++) p[i] = w[sel_pos(i)];
        return p;
    endfunction

endpackage

// File: rtl/irq_inj_decode.sv
module irq_inj_decode
    import irq_inject_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [WORD_W-1:0] wdata,
    output acc_dec_t          dec
);
    localparam logic [ADDR_W-1:0] ID_ADDR  = BASE_ADDR;
    localparam logic [ADDR_W-1:0] CMD_ADDR = BASE_ADDR + ADDR_W'(4);

    logic    shape_ok;
    logic    rsvd_hit;
    target_e tgt;

    always_comb begin
        shape_ok = (size == SIZE_WORD) && (addr[1:0] == 2'b00);
        if (addr == ID_ADDR)       tgt = TGT_ID;
        else if (addr == CMD_ADDR) tgt = TGT_CMD;
        else                       tgt = TGT_NONE;
        rsvd_hit = |(wdata[LEVEL_BIT-1:0] & ~SEL_MASK);
    end

    always_comb begin
        dec.is_write = write;
        dec.tgt      = tgt;
        dec.fault    = 1'b0;
        if (valid) begin
            if (!shape_ok || tgt == TGT_NONE)            dec.fault = 1'b1;
            else if (write && tgt == TGT_CMD && rsvd_hit) dec.fault = 1'b1;
        end
        dec.accept = valid && !dec.fault;
    end
endmodule

// File: rtl/irq_inj_lines.sv
module irq_inj_lines
    import irq_inject_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sup_mode_en,
    input  cmd_t                 cmd,
    output logic [NUM_LINES-1:0] pend
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic bit_q;
        if (i == SSW_IDX) begin : g_gated
            always_ff @(posedge clk) begin
                if (rst)                          bit_q <= 1'b0;
                else if (!sup_mode_en)            bit_q <= 1'b0;
                else if (cmd.apply && cmd.pick[i]) bit_q <= cmd.level;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)                          bit_q <= 1'b0;
                else if (cmd.apply && cmd.pick[i]) bit_q <= cmd.level;
            end
        end
        assign pend[i] = bit_q;
    end
endmodule

// File: rtl/irq_inj_rdmux.sv
module irq_inj_rdmux
    import irq_inject_pkg::*;
(
    input  acc_dec_t          dec,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (dec.accept && !dec.is_write && dec.tgt == TGT_ID) rdata = ID_WORD;
    end
endmodule

// File: rtl/irq_inject_regs.sv
module irq_inject_regs
    import irq_inject_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sup_mode_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    output logic              acc_fault,
    output logic [3:0]        irq_pend
);
    acc_dec_t dec;
    cmd_t     cmd;

    irq_inj_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .valid (acc_valid),
        .write (acc_write),
        .addr  (acc_addr),
        .size  (acc_size),
        .wdata (acc_wdata),
        .dec   (dec)
    );

    always_comb begin
        cmd.apply = dec.accept && dec.is_write && dec.tgt == TGT_CMD;
        cmd.level = acc_wdata[LEVEL_BIT];
        cmd.pick  = gather_pick(acc_wdata);
    end

    irq_inj_lines u_lines (
        .clk         (clk),
        .rst         (rst),
        .sup_mode_en (sup_mode_en),
        .cmd         (cmd),
        .pend        (irq_pend)
    );

    irq_inj_rdmux u_rd (
        .dec   (dec),
        .rdata (acc_rdata)
    );

    assign acc_fault = dec.fault;
endmodule

// File: rtl/irq_inject_chk.sv
module irq_inject_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100
) (
    input logic              clk,
    input logic              rst,
    input logic              sup_mode_en,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [2:0]        acc_size,
    input logic [31:0]       acc_wdata,
    input logic [31:0]       acc_rdata,
    input logic              acc_fault,
    input logic [3:0]        irq_pend
);
    localparam logic [ADDR_W-1:0] A_ID  = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_CMD = BASE_ADDR + ADDR_W'(4);
    localparam logic [30:0] LEGAL = 31'h0000_0A0A;

    logic word_ok;
    logic cmd_ok;
    assign word_ok = acc_valid && acc_size == 3'd2;
    assign cmd_ok  = word_ok && acc_write && acc_addr == A_CMD
                     && (acc_wdata[30:0] & ~LEGAL) == 31'd0;

    assert_bad_size_R1: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_size != 3'd2 |-> acc_fault);
    assert_misalign_R1: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_addr[1:0] != 2'b00 |-> acc_fault);
    assert_id_read_R2: assert property (@(posedge clk) disable iff (rst)
        word_ok && !acc_write && acc_addr == A_ID |-> !acc_fault && acc_rdata == 32'h0001_0000);
    assert_cmd_read_R3: assert property (@(posedge clk) disable iff (rst)
        word_ok && !acc_write && acc_addr == A_CMD |-> !acc_fault && acc_rdata == 32'd0);
    assert_unmapped_R4: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_addr != A_ID && acc_addr != A_CMD |-> acc_fault);
    assert_id_write_R5: assert property (@(posedge clk) disable iff (rst)
        word_ok && acc_write && acc_addr == A_ID && sup_mode_en
        |=> irq_pend == $past(irq_pend));
    assert_reserved_R6: assert property (@(posedge clk) disable iff (rst)
        word_ok && acc_write && acc_addr == A_CMD && (acc_wdata[30:0] & ~LEGAL) != 31'd0
        |-> acc_fault);
    assert_mext_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_ok && acc_wdata[11] |=> irq_pend[3] == $past(acc_wdata[31]));
    assert_msw_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_ok && acc_wdata[3] |=> irq_pend[1] == $past(acc_wdata[31]));
    assert_ssw_off_R8: assert property (@(posedge clk) disable iff (rst)
        !sup_mode_en |=> !irq_pend[0]);
    assert_clear_R9: assert property (@(posedge clk)
        rst |=> irq_pend == 4'd0);
    assert_fault_hold_R10: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (acc_fault || !acc_write) && sup_mode_en |=> irq_pend == $past(irq_pend));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !acc_fault && acc_rdata == 32'd0);
endmodule

bind irq_inject_regs irq_inject_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sup_mode_en (sup_mode_en),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .acc_size    (acc_size),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .acc_fault   (acc_fault),
    .irq_pend    (irq_pend)
);

// File: tb/sim_irq_inject_regs.sv
module sim_irq_inject_regs;
    localparam int unsigned AW = 6;
    localparam logic [AW-1:0] BASE = 6'h10;
    localparam logic [AW-1:0] CMDA = 6'h14;
    localparam logic [30:0] LEGAL = 31'h0000_0A0A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sup_mode_en = 1'b1;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [2:0]    acc_size = 3'd0;
    logic [31:0]   acc_wdata = '0;
    logic [31:0]   acc_rdata;
    logic          acc_fault;
    logic [3:0]    irq_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [3:0] model = 4'd0;

    always #10 clk = ~clk;

    irq_inject_regs #(.ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst(rst), .sup_mode_en(sup_mode_en),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_fault(acc_fault), .irq_pend(irq_pend)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, check response mid-cycle, check lines after edge.
    task automatic access(input logic [AW-1:0] a, input bit wr, input logic [2:0] sz,
                          input logic [31:0] d);
        bit    e_fault;
        logic [31:0] e_rd;
        string tag;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
        e_fault = !(sz == 3'd2 && (a == BASE || a == CMDA));
        if (!e_fault && wr && a == CMDA && (d[30:0] & ~LEGAL) != 31'd0) e_fault = 1'b1;
        e_rd = (!e_fault && !wr && a == BASE) ? 32'h0001_0000 : 32'd0;
        if (sz != 3'd2 || a[1:0] != 2'b00)  tag = "R1";
        else if (a != BASE && a != CMDA)     tag = "R4";
        else if (!wr && a == BASE)           tag = "R2";
        else if (!wr)                        tag = "R3";
        else if (a == BASE)                  tag = "R5";
        else if (e_fault)                    tag = "R6";
        else                                 tag = "R7";
        #2;
        check(acc_fault == e_fault, tag, {31'd0, acc_fault}, {31'd0, e_fault});
        check(acc_rdata == e_rd, tag, acc_rdata, e_rd);
        if (!e_fault && wr && a == CMDA) begin
            if (d[11]) model[3] = d[31];
            if (d[9])  model[2] = d[31];
            if (d[3])  model[1] = d[31];
            if (d[1] && sup_mode_en) model[0] = d[31];
        end
        if (!sup_mode_en) model[0] = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0;
        if (!wr || e_fault) tag = (tag == "R6") ? "R6" : "R10";
        check(irq_pend == model, tag, {28'd0, irq_pend}, {28'd0, model});
        #2;
        check(acc_fault == 1'b0 && acc_rdata == 32'd0, "R10", acc_rdata, 32'd0);
    endtask

    function automatic logic [31:0] cmd_word(input logic [3:0] m, input bit v);
        return {v, 19'd0, m[3], 1'b0, m[2], 5'd0, m[1], 1'b0, m[0], 1'b0};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(irq_pend == 4'd0, "R9", {28'd0, irq_pend}, 32'd0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R10: full address x size x direction sweep
        for (int a = 0; a < 64; a++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++)
                    access(AW'(a), w[0], 3'(s), 32'd0);

        // R7 R8: every select combination and level, mode present then absent
        for (int sm = 1; sm >= 0; sm--) begin
            sup_mode_en = sm[0];
            for (int m = 0; m < 16; m++)
                for (int v = 1; v >= 0; v--) begin
                    access(CMDA, 1'b1, 3'd2, cmd_word(4'(m), v[0]));
                    access(CMDA, 1'b1, 3'd2, cmd_word(4'(15 - m), 1'b1));
                end
        end

        // R3: control reads zero with lines set
        sup_mode_en = 1'b1;
        access(CMDA, 1'b1, 3'd2, cmd_word(4'hF, 1'b1));
        access(CMDA, 1'b0, 3'd2, 32'd0);

        // R6: each reserved bit faults, lines held
        for (int b = 0; b < 31; b++)
            if (!LEGAL[b]) access(CMDA, 1'b1, 3'd2, cmd_word(4'hF, 1'b0) | (32'd1 << b));

        // R5: version write with full data changes nothing
        access(BASE, 1'b1, 3'd2, 32'hFFFF_FFFF);

        // R8: dropping supervisor mode clears the supervisor software line
        @(negedge clk);
        sup_mode_en = 1'b0;
        @(negedge clk);
        model[0] = 1'b0;
        check(irq_pend == model, "R8", {28'd0, irq_pend}, {28'd0, model});
        // R8: selecting it while absent is accepted and leaves it zero
        access(CMDA, 1'b1, 3'd2, cmd_word(4'h1, 1'b1));

        // R9: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = 4'd0;
        check(irq_pend == 4'd0, "R9", {28'd0, irq_pend}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule